// File: doc/BRIEF.md
# Per-Bit Pattern Match Detector

This block watches a parallel input port that is sampled on every clock. It raises a sticky match flag when a pattern programmed bit by bit is satisfied. Three configuration vectors give each bit its condition. A bit can be left out, can require a low or high level, or can require a rising edge, a falling edge or any change. An edge is judged by comparing the current sample with the sample taken one clock earlier, so an edge condition is true for exactly one cycle.

The per-bit results are combined in one of four modes: off, AND, OR, or OR with priority. In priority mode only the highest-numbered matching bit is reported. The block reports the match flag, a vector of the bits that matched, and a registered copy of the port. That copy can be frozen at the sample that caused the match. An interrupt request is raised on a match. It can also be raised on a new-data strobe unless the match-only option is set. The host clears the flag, the vector, the interrupt and the frozen data with a one-cycle clear pulse.

Top module: `pattern_match_unit`

## Requirements
- R1: After synchronous reset, match_flag, match_vec, irq_req and port_data are all zero, and the first sample after reset never counts as an edge.
- R2: A bit with sel_mask=0 and sel_edge=0 is ignored. It never causes a match and never appears in match_vec.
- R3: A bit with sel_mask=0 and sel_edge=1 is true in any cycle where its sample differs from the previous clock's sample.
- R4: A bit with sel_mask=1 and sel_edge=0 requires a level: low when sel_pol=0 and high when sel_pol=1.
- R5: A bit with sel_mask=1 and sel_edge=1 requires an edge between the previous and current samples: falling when sel_pol=0 and rising when sel_pol=1.
- R6: combine_mode=0 disables matching, so match_flag never sets.
- R7: combine_mode=1 (AND) matches only when every specified bit (mask or edge set) is true in the same cycle. With no bit specified it never matches.
- R8: combine_mode=2 (OR) matches when any specified bit is true. match_vec ORs in the true bits of each match until cleared.
- R9: combine_mode=3 (OR-priority) reports only the highest-numbered true bit as a one-hot vector. A later match replaces the held vector only when its bit is numerically above the held vector, or when no match is held.
- R10: A match sets match_flag on the next clock edge. match_flag stays set until match_clear. A match in the same cycle as match_clear wins and leaves a fresh result.
- R11: port_data is the port sample from the previous clock. When latch_on_match=1 and a match is held, port_data stays at the sample that caused the match until match_clear.
- R12: irq_req sets on a match, or on data_strobe when irq_match_only=0. It holds until match_clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | WIDTH | Sampled input port |
| sel_mask | input | WIDTH | Per-bit mask select |
| sel_edge | input | WIDTH | Per-bit transition select |
| sel_pol | input | WIDTH | Per-bit polarity select |
| combine_mode | input | 2 | 0 off, 1 AND, 2 OR, 3 OR-priority |
| latch_on_match | input | 1 | Freeze port_data at the matching sample |
| irq_match_only | input | 1 | Ignore data_strobe for interrupts |
| data_strobe | input | 1 | New-data event for the interrupt |
| match_clear | input | 1 | Host clear of flag, vector, interrupt and frozen data |
| match_flag | output | 1 | Sticky match status |
| match_vec | output | WIDTH | Bits that produced the held match |
| port_data | output | WIDTH | Registered or frozen port sample |
| irq_req | output | 1 | Interrupt request |

## Verification
Every output is registered, so a wrong condition decode or combine result shows up one clock after the stimulus. It appears on match_flag and on match_vec, which must be zero exactly when the flag is clear. A stale previous-sample register makes an edge condition fire one cycle early or late, or right after reset. The bench catches this at once with back-to-back toggles. A wrong priority or hold decision becomes visible on port_data or match_vec in the cycle after a competing match or clear.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        CMB_OFF  = 2'd0,
        CMB_AND  = 2'd1,
        CMB_OR   = 2'd2,
        CMB_PRIO = 2'd3
    } combine_e;

    typedef struct packed {
        logic mask;
        logic edge_sel;
        logic pol;
    } bit_cfg_t;

    typedef struct packed {
        logic cur;
        logic prev;
        logic prev_ok;
    } bit_smp_t;

    function automatic logic bit_specified(input bit_cfg_t c);
        return c.mask | c.edge_sel;
    endfunction

    function automatic logic bit_condition(input bit_cfg_t c, input bit_smp_t s);
        logic r;
        case ({c.mask, c.edge_sel})
            2'b00:   r = 1'b0;
            2'b01:   r = s.prev_ok & (s.cur ^ s.prev);
            2'b10:   r = (s.cur == c.pol);
            default: r = s.prev_ok & (s.cur == c.pol) & (s.prev != c.pol);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pm_bit_eval.sv
module pm_bit_eval
    import pm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] port_in,
    input  logic [WIDTH-1:0] sel_mask,
    input  logic [WIDTH-1:0] sel_edge,
    input  logic [WIDTH-1:0] sel_pol,
    output logic [WIDTH-1:0] bit_true,
    output logic [WIDTH-1:0] bit_spec
);
    logic [WIDTH-1:0] prev_q;
    logic             prev_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else begin
            prev_q    <= port_in;
            prev_ok_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bit_cfg_t cfg;
        bit_smp_t smp;
        always_comb begin
            cfg.mask     = sel_mask[i];
            cfg.edge_sel = sel_edge[i];
            cfg.pol      = sel_pol[i];
            smp.cur      = port_in[i];
            smp.prev     = prev_q[i];
            smp.prev_ok  = prev_ok_q;
            bit_true[i]  = bit_condition(cfg, smp);
            bit_spec[i]  = bit_specified(cfg);
        end
    end
endmodule

// File: rtl/pm_combine.sv
module pm_combine
    import pm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bit_true,
    input  logic [WIDTH-1:0] bit_spec,
    input  logic [1:0]       combine_mode,
    output logic             hit_ev,
    output logic [WIDTH-1:0] hit_vec
);
    logic [WIDTH-1:0] live;
    logic [WIDTH-1:0] top_bit;
    logic             all_ok;
    combine_e         mode;

    assign mode   = combine_e'(combine_mode);
    assign live   = bit_true & bit_spec;
    assign all_ok = (bit_spec != '0) && ((bit_true | ~bit_spec) == '1);

    always_comb begin
        top_bit = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (live[i]) top_bit = WIDTH'(1) << i;
        end
    end

    always_comb begin
        case (mode)
            CMB_AND: begin
                hit_ev  = all_ok;
                hit_vec = bit_spec;
            end
            CMB_OR: begin
                hit_ev  = (live != '0);
                hit_vec = live;
            end
            CMB_PRIO: begin
                hit_ev  = (live != '0);
                hit_vec = top_bit;
            end
            default: begin
                hit_ev  = 1'b0;
                hit_vec = '0;
            end
        endcase
    end
endmodule

// File: rtl/pm_status.sv
module pm_status
    import pm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] port_in,
    input  logic             hit_ev,
    input  logic [WIDTH-1:0] hit_vec,
    input  logic [1:0]       combine_mode,
    input  logic             latch_on_match,
    input  logic             irq_match_only,
    input  logic             data_strobe,
    input  logic             match_clear,
    output logic             match_flag,
    output logic [WIDTH-1:0] match_vec,
    output logic [WIDTH-1:0] port_data,
    output logic             irq_req
);
    logic             flag_q, irq_q;
    logic [WIDTH-1:0] vec_q, cap_q;
    logic             keep_flag;
    logic [WIDTH-1:0] keep_vec;
    logic [WIDTH-1:0] vec_d;
    logic             prio_mode;

    assign keep_flag = flag_q & ~match_clear;
    assign keep_vec  = match_clear ? '0 : vec_q;
    assign prio_mode = (combine_e'(combine_mode) == CMB_PRIO);

    always_comb begin
        vec_d = keep_vec;
        if (hit_ev) begin
            if (prio_mode) begin
                if (!keep_flag || (hit_vec > keep_vec)) vec_d = hit_vec;
            end else begin
                vec_d = keep_vec | hit_vec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            vec_q  <= '0;
            cap_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= hit_ev | keep_flag;
            vec_q  <= vec_d;
            irq_q  <= hit_ev | (data_strobe & ~irq_match_only) | (irq_q & ~match_clear);
            if (!(latch_on_match && keep_flag)) cap_q <= port_in;
        end
    end

    assign match_flag = flag_q;
    assign match_vec  = vec_q;
    assign port_data  = cap_q;
    assign irq_req    = irq_q;
endmodule

// File: rtl/pattern_match_unit.sv
module pattern_match_unit
    import pm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] port_in,
    input  logic [WIDTH-1:0] sel_mask,
    input  logic [WIDTH-1:0] sel_edge,
    input  logic [WIDTH-1:0] sel_pol,
    input  logic [1:0]       combine_mode,
    input  logic             latch_on_match,
    input  logic             irq_match_only,
    input  logic             data_strobe,
    input  logic             match_clear,
    output logic             match_flag,
    output logic [WIDTH-1:0] match_vec,
    output logic [WIDTH-1:0] port_data,
    output logic             irq_req
);
    logic [WIDTH-1:0] bit_true, bit_spec, hit_vec;
    logic             hit_ev;

    pm_bit_eval #(.WIDTH(WIDTH)) u_eval (
        .clk(clk), .rst(rst), .port_in(port_in),
        .sel_mask(sel_mask), .sel_edge(sel_edge), .sel_pol(sel_pol),
        .bit_true(bit_true), .bit_spec(bit_spec)
    );

    pm_combine #(.WIDTH(WIDTH)) u_comb (
        .bit_true(bit_true), .bit_spec(bit_spec), .combine_mode(combine_mode),
        .hit_ev(hit_ev), .hit_vec(hit_vec)
    );

    pm_status #(.WIDTH(WIDTH)) u_stat (
        .clk(clk), .rst(rst), .port_in(port_in),
        .hit_ev(hit_ev), .hit_vec(hit_vec), .combine_mode(combine_mode),
        .latch_on_match(latch_on_match), .irq_match_only(irq_match_only),
        .data_strobe(data_strobe), .match_clear(match_clear),
        .match_flag(match_flag), .match_vec(match_vec),
        .port_data(port_data), .irq_req(irq_req)
    );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       combine_mode,
    input logic             latch_on_match,
    input logic             irq_match_only,
    input logic             data_strobe,
    input logic             match_clear,
    input logic             hit_ev,
    input logic             match_flag,
    input logic [WIDTH-1:0] match_vec,
    input logic [WIDTH-1:0] port_data,
    input logic             irq_req
);
    assert_mode_off_R6: assert property (@(posedge clk) disable iff (rst)
        (combine_mode == 2'd0 && !match_flag) |=> !match_flag);

    assert_flag_vec_R10: assert property (@(posedge clk) disable iff (rst)
        match_flag == (match_vec != '0));

    assert_hit_sets_R10: assert property (@(posedge clk) disable iff (rst)
        hit_ev |=> match_flag);

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (match_clear && !hit_ev) |=> !match_flag);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !match_clear) |=> match_flag);

    assert_prio_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        (combine_mode == 2'd3 && hit_ev && (match_clear || !match_flag)) |=> $onehot(match_vec));

    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (latch_on_match && match_flag && !match_clear) |=> $stable(port_data));

    assert_irq_hit_R12: assert property (@(posedge clk) disable iff (rst)
        hit_ev |=> irq_req);

    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !hit_ev && (irq_match_only || !data_strobe)) |=> !irq_req);
endmodule

bind pattern_match_unit pm_checker #(.WIDTH(WIDTH)) u_pm_checker (
    .clk(clk), .rst(rst), .combine_mode(combine_mode),
    .latch_on_match(latch_on_match), .irq_match_only(irq_match_only),
    .data_strobe(data_strobe), .match_clear(match_clear), .hit_ev(hit_ev),
    .match_flag(match_flag), .match_vec(match_vec),
    .port_data(port_data), .irq_req(irq_req)
);

// File: tb/test_pattern_match_unit.sv
module test_pattern_match_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] port_in = '0, sel_mask = '0, sel_edge = '0, sel_pol = '0;
    logic [1:0]   combine_mode = 2'd0;
    logic         latch_on_match = 1'b0, irq_match_only = 1'b0;
    logic         data_strobe = 1'b0, match_clear = 1'b0;
    logic         match_flag, irq_req;
    logic [W-1:0] match_vec, port_data;

    int errors = 0;
    int checks = 0;

    logic [W-1:0] m_prev = '0, m_vec = '0, m_cap = '0;
    logic         m_pok = 1'b0, m_flag = 1'b0, m_irq = 1'b0;

    always #2 clk = ~clk;

    pattern_match_unit #(.WIDTH(W)) i_pattern_match_unit (
        .clk(clk), .rst(rst), .port_in(port_in),
        .sel_mask(sel_mask), .sel_edge(sel_edge), .sel_pol(sel_pol),
        .combine_mode(combine_mode), .latch_on_match(latch_on_match),
        .irq_match_only(irq_match_only), .data_strobe(data_strobe),
        .match_clear(match_clear), .match_flag(match_flag),
        .match_vec(match_vec), .port_data(port_data), .irq_req(irq_req)
    );

    task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic cond(input logic m, input logic e, input logic p, input logic cur, input logic prv, input logic ok);
        case ({m, e})
            2'b00:   return 1'b0;
            2'b01:   return ok && (cur != prv);
            2'b10:   return cur == p;
            default: return ok && (cur == p) && (prv != p);
        endcase
    endfunction

    // Model update for the inputs now applied; then compare after the edge.
    task automatic step(input string req);
        logic [W-1:0] tru, spec, live, nv, kv, top;
        logic ev, kf;
        for (int i = 0; i < W; i++)
            tru[i] = cond(sel_mask[i], sel_edge[i], sel_pol[i], port_in[i], m_prev[i], m_pok);
        spec = sel_mask | sel_edge;
        live = tru & spec;
        top = '0;
        for (int i = 0; i < W; i++) if (live[i]) top = '0 | (W'(1) << i);
        case (combine_mode)
            2'd1: begin ev = (spec != '0) && ((tru | ~spec) == '1); nv = spec; end
            2'd2: begin ev = (live != '0); nv = live; end
            2'd3: begin ev = (live != '0); nv = top; end
            default: begin ev = 1'b0; nv = '0; end
        endcase
        kf = m_flag & ~match_clear;
        kv = match_clear ? '0 : m_vec;
        if (ev) begin
            if (combine_mode == 2'd3) m_vec = (!kf || nv > kv) ? nv : kv;
            else m_vec = kv | nv;
        end else m_vec = kv;
        m_irq  = ev | (data_strobe & ~irq_match_only) | (m_irq & ~match_clear);
        if (!(latch_on_match && kf)) m_cap = port_in;
        m_flag = ev | kf;
        m_prev = port_in;
        m_pok  = 1'b1;
        @(negedge clk);
        chk(req, "flag", W'(match_flag), W'(m_flag));
        chk(req, "vec", match_vec, m_vec);
        chk("R11", "data", port_data, m_cap);
        chk("R12", "irq", W'(irq_req), W'(m_irq));
    endtask

    task automatic clear_pulse(input string req);
        match_clear = 1'b1;
        step(req);
        match_clear = 1'b0;
    endtask

    task automatic cfg(input logic [W-1:0] m, input logic [W-1:0] e, input logic [W-1:0] p, input logic [1:0] md);
        sel_mask = m; sel_edge = e; sel_pol = p; combine_mode = md;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "flag", W'(match_flag), '0);
        chk("R1", "vec", match_vec, '0);
        chk("R1", "data", port_data, '0);
        chk("R1", "irq", W'(irq_req), '0);
        // R1/R5: first sample after reset is not an edge
        cfg(8'h01, 8'h01, 8'h01, 2'd2); port_in = 8'h01; step("R1");
        clear_pulse("R10");

        // R2: ignored bits toggle, only bit 0 level-high specified, held low
        cfg(8'h01, 8'h00, 8'h01, 2'd2);
        for (int k = 0; k < 20; k++) begin port_in = 8'($urandom) & 8'hFE; step("R2"); end
        // R3: any transition on bit 3
        cfg(8'h00, 8'h08, 8'h00, 2'd2);
        port_in = 8'h00; step("R3"); clear_pulse("R3");
        port_in = 8'h08; step("R3"); clear_pulse("R3");
        port_in = 8'h00; step("R3");
        // R4: levels, bit1 low and bit6 high, AND
        cfg(8'h42, 8'h00, 8'h40, 2'd1); clear_pulse("R4");
        port_in = 8'h02; step("R4"); port_in = 8'h40; step("R4"); clear_pulse("R4");
        // R5: rising on bit 2, falling on bit 5, OR
        cfg(8'h24, 8'h24, 8'h04, 2'd2); port_in = 8'h20; step("R5"); clear_pulse("R5");
        port_in = 8'h24; step("R5"); step("R5"); clear_pulse("R5");
        port_in = 8'h04; step("R5"); clear_pulse("R5");
        // R6: disabled mode
        cfg(8'hFF, 8'h00, 8'hFF, 2'd0);
        for (int k = 0; k < 10; k++) begin port_in = 8'($urandom); step("R6"); end
        // R7: AND with edge and level in same cycle; nothing specified
        cfg(8'h11, 8'h01, 8'h11, 2'd1); port_in = 8'h10; step("R7"); clear_pulse("R7");
        port_in = 8'h11; step("R7"); clear_pulse("R7");
        cfg(8'h00, 8'h00, 8'h00, 2'd1); port_in = 8'h5A; step("R7");
        // R8: OR accumulation
        cfg(8'hFF, 8'h00, 8'hFF, 2'd2); port_in = 8'h03; step("R8"); port_in = 8'h30; step("R8");
        clear_pulse("R8");
        // R9: priority replace and keep
        cfg(8'hFF, 8'h00, 8'hFF, 2'd3); port_in = 8'h00; clear_pulse("R9");
        port_in = 8'h06; step("R9"); port_in = 8'h01; step("R9");
        port_in = 8'h81; step("R9"); port_in = 8'h10; step("R9");
        // R10: match during clear wins; clear without match drops
        port_in = 8'h20; clear_pulse("R10"); port_in = 8'h00; clear_pulse("R10"); step("R10");
        // R11: latch on match, hold then release
        latch_on_match = 1'b1; cfg(8'h80, 8'h80, 8'h80, 2'd2);
        port_in = 8'h00; step("R11"); port_in = 8'h85; step("R11");
        for (int k = 0; k < 5; k++) begin port_in = 8'($urandom) & 8'h7F; step("R11"); end
        clear_pulse("R11"); step("R11");
        latch_on_match = 1'b0;
        // R12: strobe interrupts with and without match-only
        cfg(8'h00, 8'h00, 8'h00, 2'd2);
        irq_match_only = 1'b1; data_strobe = 1'b1; step("R12"); data_strobe = 1'b0; step("R12");
        irq_match_only = 1'b0; data_strobe = 1'b1; step("R12"); data_strobe = 1'b0; step("R12");
        clear_pulse("R12");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            if (k % 50 == 0) begin
                sel_mask = 8'($urandom); sel_edge = 8'($urandom); sel_pol = 8'($urandom);
                combine_mode = 2'($urandom); latch_on_match = 1'($urandom);
                irq_match_only = 1'($urandom);
            end
            port_in = ($urandom % 4 == 0) ? 8'($urandom) : port_in ^ (8'h01 << ($urandom % 8));
            data_strobe = ($urandom % 8 == 0);
            match_clear = ($urandom % 6 == 0);
            case (combine_mode)
                2'd0: step("R6");
                2'd1: step("R7");
                2'd2: step("R8");
                default: step("R9");
            endcase
        end
        match_clear = 1'b0; data_strobe = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule